// File: doc/BRIEF.md
# Burst-Correcting Codeword Decoder for Paged Message Words

This block checks and repairs one 32-bit codeword at a time, as found in the words that follow a recognised address in a paging stream. The upper 31 bits form a shortened cyclic code with 21 information bits and 10 check bits. The lowest bit is an even-parity bit over the other 31 bits. The block repairs any error in one bit, and any error that hits two neighbouring bits of the 31-bit body. It marks two separated errors, and any three errors, as beyond repair. It then reports the repaired word together with a two-bit error code.

After repair, the top bit of the word decides what happens to reception. A 1 marks a message word, so reception goes on. A 0 marks an idle word, so the block raises an end-of-message indication. A break-terminated mode input overrides this: with it set, every word counts as a message and no end-of-message is raised. The block takes one word per strobe. Decoding walks the error patterns one position per clock and gives a fixed latency of 32 clocks. The result appears with a single-cycle valid pulse.

Top module: `bch_msg_decoder`

## Requirements
- R1: The codeword layout is as follows. Bits [31:1] are the code body, where bit k+1 is the coefficient of x^k, and they must be a multiple of x^10+x^9+x^8+x^6+x^5+x^3+1. Bits [31:11] carry the information, and bit 0 makes the parity of all 32 bits even. A word with no error comes back unchanged, with res_flags = 2'b00.
- R2: A single wrong bit at any of the 32 positions, including the parity bit, is repaired, and res_flags = 2'b01.
- R3: Two wrong bits at neighbouring positions p and p+1, with 1 <= p <= 30 (both inside bits [31:1]), are repaired, and res_flags = 2'b10.
- R4: Two wrong bits at positions that are not neighbours, or any three wrong bits, give res_flags = 2'b11. In that case res_data equals the received word unchanged.
- R5: When res_data[31] = 1, the result has res_msg = 1 and res_eom = 0.
- R6: When res_data[31] = 0 and break mode was off at the strobe, the result has res_msg = 0 and res_eom = 1. A top bit repaired from 0 to 1 counts as a message.
- R7: When brk_mode = 1 at the strobe, the result has res_msg = 1 and res_eom = 0 whatever the top bit is.
- R8: res_valid is a one-cycle pulse. It is set by the 32nd rising clock edge after the edge that accepts cw_valid, which is within 64 cycles. res_eom is only ever high together with res_valid.
- R9: A cw_valid strobe that arrives while a word is still being decoded is ignored. It yields no extra result and does not disturb the current one.
- R10: While reset is asserted, and after it is released, res_valid and res_eom are 0 until a word is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cw_valid | input | 1 | Strobe: cw_data holds a codeword |
| cw_data | input | 32 | Received codeword |
| brk_mode | input | 1 | Break-terminated mode, sampled with the strobe |
| res_valid | output | 1 | One-cycle result pulse |
| res_data | output | 32 | Repaired word, or the raw word when not repairable |
| res_flags | output | 2 | 00 clean, 01 single repaired, 10 adjacent pair repaired, 11 not repairable |
| res_msg | output | 1 | Word treated as message, so reception continues |
| res_eom | output | 1 | End-of-message indication for an idle word |

## Verification
The decoder is driven with the following codeword patterns:
- Clean codewords, to confirm that a zero syndrome with even parity changes nothing.
- Single flips at every kind of position: the top bit, the parity bit, and random body bits. These separate the parity-only path from the syndrome-table path.
- Adjacent pairs at both ends of the body and at random places. These show that burst syndromes resolve to the right pair rather than to a single bit.
- Separated pairs and random triples, including a body bit together with the parity bit. These show that the parity cross-check rejects aliased corrections.

Break mode is toggled against words with the top bit both set and clear, including a top bit repaired from 0 to 1. A second strobe injected mid-decode shows that the busy interval is respected.

// File: rtl/bchdec_pkg.sv
package bchdec_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BODY_W = WORD_W - 1;
  localparam int unsigned CHK_W  = 10;
  localparam int unsigned POS_W  = $clog2(BODY_W);
  localparam logic [CHK_W:0] GEN_POLY = 11'h769;

  typedef enum logic [1:0] {
    FLG_CLEAN  = 2'b00,
    FLG_SINGLE = 2'b01,
    FLG_PAIR   = 2'b10,
    FLG_FAIL   = 2'b11
  } flag_e;

  typedef enum logic [1:0] {
    HIT_NONE   = 2'b00,
    HIT_SINGLE = 2'b01,
    HIT_PAIR   = 2'b10
  } hit_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SCAN = 2'b01,
    ST_FIN  = 2'b10
  } state_e;

  // multiply a residue by x modulo the generator
  function automatic logic [CHK_W-1:0] mul_x(input logic [CHK_W-1:0] r);
    mul_x = {r[CHK_W-2:0], 1'b0} ^ (r[CHK_W-1] ? GEN_POLY[CHK_W-1:0] : '0);
  endfunction
endpackage

// File: rtl/bch_syn_calc.sv
module bch_syn_calc
  import bchdec_pkg::*;
#(
  parameter int unsigned W_WORD = WORD_W,
  parameter int unsigned W_CHK  = CHK_W
) (
  input  logic [W_WORD-1:0] word_i,
  output logic [W_CHK-1:0]  syn_o
);
  localparam int unsigned W_BODY = W_WORD - 1;

  logic [W_CHK-1:0] acc;
  logic             fb;

  // body bit k (word bit k+1) is the coefficient of x^k; Horner from the top
  always_comb begin
    acc = '0;
    fb  = 1'b0;
    for (int i = W_BODY - 1; i >= 0; i--) begin
      fb  = acc[W_CHK-1];
      acc = {acc[W_CHK-2:0], word_i[i+1]} ^ (fb ? GEN_POLY[W_CHK-1:0] : '0);
    end
    syn_o = acc;
  end
endmodule

// File: rtl/bch_pattern_scan.sv
module bch_pattern_scan
  import bchdec_pkg::*;
#(
  parameter int unsigned W_CHK  = CHK_W,
  parameter int unsigned W_POS  = POS_W,
  parameter int unsigned N_BODY = BODY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [W_CHK-1:0] syn_i,
  output hit_e             kind_o,
  output logic [W_POS-1:0] pos_o,
  output logic             last_o
);
  localparam logic [W_POS-1:0] LAST_IDX = W_POS'(N_BODY - 1);

  logic [W_CHK-1:0] pow_q, pow_d;
  logic [W_POS-1:0] idx_q, idx_d;
  logic [W_POS-1:0] pos_q, pos_d;
  hit_e             kind_q, kind_d;
  logic             en;
  logic [W_CHK-1:0] pair_syn;

  assign en       = start_i | step_i;
  assign pair_syn = pow_q ^ mul_x(pow_q);
  assign last_o   = (idx_q == LAST_IDX);

  always_comb begin
    pow_d  = pow_q;
    idx_d  = idx_q;
    pos_d  = pos_q;
    kind_d = kind_q;
    if (start_i) begin
      pow_d  = W_CHK'(1);
      idx_d  = '0;
      pos_d  = '0;
      kind_d = HIT_NONE;
    end else if (step_i) begin
      if (pow_q == syn_i) begin
        kind_d = HIT_SINGLE;
        pos_d  = idx_q;
      end else if (!last_o && (pair_syn == syn_i)) begin
        kind_d = HIT_PAIR;
        pos_d  = idx_q;
      end
      pow_d = mul_x(pow_q);
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pow_q  <= W_CHK'(1);
      idx_q  <= '0;
      pos_q  <= '0;
      kind_q <= HIT_NONE;
    end else if (en) begin
      pow_q  <= pow_d;
      idx_q  <= idx_d;
      pos_q  <= pos_d;
      kind_q <= kind_d;
    end
  end

  assign kind_o = kind_q;
  assign pos_o  = pos_q;
endmodule

// File: rtl/bch_fix_classify.sv
module bch_fix_classify
  import bchdec_pkg::*;
#(
  parameter int unsigned W_WORD = WORD_W,
  parameter int unsigned W_POS  = POS_W
) (
  input  logic [W_WORD-1:0] word_i,
  input  logic              syn_zero_i,
  input  hit_e              kind_i,
  input  logic [W_POS-1:0]  pos_i,
  input  logic              brk_i,
  output logic [W_WORD-1:0] data_o,
  output flag_e             flags_o,
  output logic              msg_o,
  output logic              eom_o
);
  logic [W_WORD-1:0] mask;
  logic [W_WORD-1:0] fixed;
  logic              raw_odd;
  logic              fix_odd;

  always_comb begin
    case (kind_i)
      HIT_SINGLE: mask = W_WORD'(1) << (pos_i + 1'b1);
      HIT_PAIR:   mask = W_WORD'(3) << (pos_i + 1'b1);
      default:    mask = '0;
    endcase
  end

  assign fixed   = word_i ^ mask;
  assign raw_odd = ^word_i;
  assign fix_odd = ^fixed;

  always_comb begin
    if (syn_zero_i) begin
      if (!raw_odd) begin
        data_o  = word_i;
        flags_o = FLG_CLEAN;
      end else begin
        data_o  = word_i ^ W_WORD'(1);
        flags_o = FLG_SINGLE;
      end
    end else if ((kind_i != HIT_NONE) && !fix_odd) begin
      data_o  = fixed;
      flags_o = (kind_i == HIT_PAIR) ? FLG_PAIR : FLG_SINGLE;
    end else begin
      data_o  = word_i;
      flags_o = FLG_FAIL;
    end
  end

  assign msg_o = brk_i | data_o[W_WORD-1];
  assign eom_o = ~msg_o;
endmodule

// File: rtl/bch_msg_decoder.sv
module bch_msg_decoder
  import bchdec_pkg::*;
#(
  parameter int unsigned W_WORD = WORD_W,
  parameter int unsigned W_CHK  = CHK_W,
  parameter int unsigned W_POS  = POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_valid,
  input  logic [W_WORD-1:0] cw_data,
  input  logic              brk_mode,
  output logic              res_valid,
  output logic [W_WORD-1:0] res_data,
  output logic [1:0]        res_flags,
  output logic              res_msg,
  output logic              res_eom
);
  localparam int unsigned N_BODY = W_WORD - 1;

  logic              rst_meta, rst_sync;
  state_e            state_q, state_d;
  logic [W_WORD-1:0] word_q;
  logic [W_CHK-1:0]  syn_q, syn_in;
  logic              brk_q;
  logic              accept, step, finish, last_idx;
  hit_e              hit_kind;
  logic [W_POS-1:0]  hit_pos;
  logic [W_WORD-1:0] fix_data;
  flag_e             fix_flags;
  logic              fix_msg, fix_eom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bch_syn_calc #(.W_WORD(W_WORD), .W_CHK(W_CHK)) u_syn (
    .word_i (cw_data),
    .syn_o  (syn_in)
  );

  assign accept = (state_q == ST_IDLE) & cw_valid;
  assign step   = (state_q == ST_SCAN);
  assign finish = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (cw_valid) state_d = ST_SCAN;
      ST_SCAN: if (last_idx) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) state_q <= ST_IDLE;
    else           state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      word_q <= '0;
      syn_q  <= '0;
      brk_q  <= 1'b0;
    end else if (accept) begin
      word_q <= cw_data;
      syn_q  <= syn_in;
      brk_q  <= brk_mode;
    end
  end

  bch_pattern_scan #(.W_CHK(W_CHK), .W_POS(W_POS), .N_BODY(N_BODY)) u_scan (
    .clk     (clk),
    .rst_n   (rst_sync),
    .start_i (accept),
    .step_i  (step),
    .syn_i   (syn_q),
    .kind_o  (hit_kind),
    .pos_o   (hit_pos),
    .last_o  (last_idx)
  );

  bch_fix_classify #(.W_WORD(W_WORD), .W_POS(W_POS)) u_fix (
    .word_i     (word_q),
    .syn_zero_i (syn_q == '0),
    .kind_i     (hit_kind),
    .pos_i      (hit_pos),
    .brk_i      (brk_q),
    .data_o     (fix_data),
    .flags_o    (fix_flags),
    .msg_o      (fix_msg),
    .eom_o      (fix_eom)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      res_valid <= 1'b0;
      res_eom   <= 1'b0;
    end else begin
      res_valid <= finish;
      res_eom   <= finish & fix_eom;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      res_data  <= '0;
      res_flags <= FLG_CLEAN;
      res_msg   <= 1'b0;
    end else if (finish) begin
      res_data  <= fix_data;
      res_flags <= fix_flags;
      res_msg   <= fix_msg;
    end
  end
endmodule

// File: rtl/bch_msg_decoder_chk.sv
module bch_msg_decoder_chk #(
  parameter int unsigned W_WORD = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cw_valid,
  input logic [W_WORD-1:0] cw_data,
  input logic              brk_mode,
  input logic              res_valid,
  input logic [W_WORD-1:0] res_data,
  input logic [1:0]        res_flags,
  input logic              res_msg,
  input logic              res_eom
);
  logic       busy_c;
  logic [6:0] cnt_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      cnt_c  <= '0;
    end else if (res_valid || !busy_c) begin
      busy_c <= cw_valid;
      cnt_c  <= '0;
    end else if (cnt_c != 7'h7f) begin
      cnt_c  <= cnt_c + 1'b1;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_EOM_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_eom |-> res_valid); // R8
  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (busy_c && cnt_c < 7'd64)); // R8
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_c |-> !res_valid); // R9
  AST_FIXED_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_flags != 2'b11) |-> !(^res_data)); // R1
  AST_MSB_IS_MESSAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_data[W_WORD-1]) |-> (res_msg && !res_eom)); // R5
  AST_IDLE_EOM: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_msg) |-> res_eom); // R6
endmodule

bind bch_msg_decoder bch_msg_decoder_chk #(.W_WORD(W_WORD)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cw_valid  (cw_valid),
  .cw_data   (cw_data),
  .brk_mode  (brk_mode),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_flags (res_flags),
  .res_msg   (res_msg),
  .res_eom   (res_eom)
);

// File: tb/bch_msg_decoder_tb.sv
`timescale 1ns/1ps
module bch_msg_decoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cw_valid;
  logic [31:0] cw_data;
  logic        brk_mode;
  logic        res_valid;
  logic [31:0] res_data;
  logic [1:0]  res_flags;
  logic        res_msg;
  logic        res_eom;

  int n_chk;
  int n_fail;
  bit done;

  bch_msg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_data(cw_data),
    .brk_mode(brk_mode), .res_valid(res_valid), .res_data(res_data),
    .res_flags(res_flags), .res_msg(res_msg), .res_eom(res_eom)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] encode(input logic [20:0] info);
    logic [30:0] t;
    logic [30:0] body;
    t = {info, 10'b0};
    for (int i = 30; i >= 10; i--)
      if (t[i]) t = t ^ (31'(11'h769) << (i - 10));
    body = {info, t[9:0]};
    return {body, ^body};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one word, wait for its result, compare with expectations
  task automatic run_case(input logic [31:0] w, input bit brk,
                          input logic [31:0] exp_data, input logic [1:0] exp_flags,
                          input string tag, input bit inject);
    int  n;
    int  extra;
    bit  exp_msg;
    exp_msg = brk | exp_data[31];
    @(negedge clk);
    cw_valid = 1'b1; cw_data = w; brk_mode = brk;
    @(negedge clk);
    cw_valid = 1'b0; brk_mode = ~brk; n = 1;
    while (!res_valid && n < 80) begin
      @(negedge clk);
      n++;
      if (inject && n == 10) begin cw_valid = 1'b1; cw_data = ~w; end
      else cw_valid = 1'b0;
    end
    chk(n == 33, "R8 latency", 32'(n), 32'd33);
    chk(res_data == exp_data, {tag, " data"}, res_data, exp_data);
    chk(res_flags == exp_flags, {tag, " flags"}, 32'(res_flags), 32'(exp_flags));
    chk(res_msg == exp_msg, exp_msg ? "R5/R7 msg" : "R6 msg", 32'(res_msg), 32'(exp_msg));
    chk(res_eom == !exp_msg, exp_msg ? "R5/R7 eom" : "R6 eom", 32'(res_eom), 32'(!exp_msg));
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 pulse width", 32'(res_valid), 32'd0);
    if (inject) begin
      extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (res_valid) extra++;
      end
      chk(extra == 0, "R9 ignored strobe", 32'(extra), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] cw, rx, ed;
    logic [1:0]  ef;
    int a, b, c, kind;
    bit brk;
    n_chk = 0; n_fail = 0; done = 0;
    cw_valid = 0; cw_data = '0; brk_mode = 0; rst_n = 0;
    void'($urandom(32'h1c3a_5e01));
    repeat (3) @(negedge clk);
    chk(res_valid == 0 && res_eom == 0, "R10 in reset", {30'b0, res_valid, res_eom}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(res_valid == 0 && res_eom == 0, "R10 after release", {30'b0, res_valid, res_eom}, 32'd0);

    // directed corners
    cw = encode(21'h1abcde | 21'h100000);
    run_case(cw, 0, cw, 2'b00, "R1 clean msg", 0);
    cw = encode(21'h0f0f0f);
    run_case(cw, 0, cw, 2'b00, "R6 clean idle", 0);
    run_case(cw, 1, cw, 2'b00, "R7 idle under break", 0);
    run_case(cw ^ 32'h1, 0, cw, 2'b01, "R2 parity bit", 0);
    cw = encode(21'h1fffff);
    run_case(cw ^ 32'h8000_0000, 0, cw, 2'b01, "R2 R6 top bit repaired", 0);
    run_case(cw ^ 32'hc000_0000, 0, cw, 2'b10, "R3 pair top", 0);
    run_case(cw ^ 32'h0000_0006, 1, cw, 2'b10, "R3 pair bottom", 0);
    run_case(cw ^ 32'h0000_0021, 0, cw ^ 32'h21, 2'b11, "R4 body+parity", 0);
    run_case(cw ^ 32'h0000_0003, 0, cw ^ 32'h3, 2'b11, "R4 bit1+parity", 0);
    cw = encode(21'h155555);
    run_case(cw ^ 32'h0001_0000, 0, cw, 2'b01, "R9 busy word", 1);

    // constrained random
    for (int it = 0; it < 60; it++) begin
      cw   = encode(21'($urandom));
      brk  = bit'($urandom % 2);
      kind = int'($urandom % 5);
      a = int'($urandom % 32);
      case (kind)
        0: begin rx = cw; ed = cw; ef = 2'b00; end
        1: begin rx = cw ^ (32'h1 << a); ed = cw; ef = 2'b01; end
        2: begin a = 1 + int'($urandom % 30); rx = cw ^ (32'h3 << a); ed = cw; ef = 2'b10; end
        3: begin
          b = int'($urandom % 32);
          while (b == a || b == a + 1 || b == a - 1) b = int'($urandom % 32);
          rx = cw ^ (32'h1 << a) ^ (32'h1 << b); ed = rx; ef = 2'b11;
        end
        default: begin
          b = int'($urandom % 32);
          while (b == a) b = int'($urandom % 32);
          c = int'($urandom % 32);
          while (c == a || c == b) c = int'($urandom % 32);
          rx = cw ^ (32'h1 << a) ^ (32'h1 << b) ^ (32'h1 << c); ed = rx; ef = 2'b11;
        end
      endcase
      run_case(rx, brk, ed, ef,
               kind == 0 ? "R1 rnd" : kind == 1 ? "R2 rnd" : kind == 2 ? "R3 rnd" : "R4 rnd", 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule